// File: doc/BRIEF.md
# Register-Triggered Integer Divider

This block divides two integers held in memory-mapped operand registers. Software writes the dividend and the divisor through a small write port. Each operand can be reached at two addresses. One address starts an unsigned division and the other starts a signed one. Both addresses of an operand land in the same storage word.

Every operand write starts a fresh calculation, using the operands as they stand after that write. Any division still in progress is dropped. A ready flag drops for a fixed number of cycles, and then the quotient and remainder registers show the answer.

The datapath retires several quotient bits per cycle with an unrolled shift-subtract stage. It works on operand magnitudes and fixes the signs at the end. Division by zero and the one overflowing signed case give defined results and raise no exception.

Top module: `regdiv_unit`

## Requirements
- R1: After a synchronous reset, `ready` is 1, `quotient` and `remainder` are 0, and both operand words hold 0. A divisor-only write after reset therefore divides 0 and gives quotient 0 and remainder 0.
- R2: `wr_sel` decodes as follows:
  - bit 0 picks the operand: 0 is the dividend, 1 is the divisor.
  - bit 1 picks the mode: 0 is unsigned, 1 is signed.
  - Both modes of an operand write the same storage word, and the other operand keeps its value.
- R3: A cycle with `wr_en` high is a write. After the edge that takes it, `ready` is 0 for exactly WIDTH/STEP_BITS cycles, and then it returns to 1. The new results are present in the same cycle that `ready` returns to 1.
- R4: A write while a calculation runs abandons that calculation. The outcome then depends only on the latest operands and mode, and `ready` returns WIDTH/STEP_BITS cycles after the latest write.
- R5: The mode of a calculation is taken from bit 1 of `wr_sel` in the latest write, whichever operand that write touched.
- R6: In unsigned mode with a nonzero divisor, `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor.
- R7: In signed mode with a nonzero divisor (two's complement), the quotient is truncated toward zero, and the remainder is zero or has the sign of the dividend.
- R8: Unsigned division by zero gives a quotient of all ones and a remainder equal to the dividend.
- R9: Signed division by zero gives a quotient of -1 when the dividend is zero or positive, and +1 when it is negative. The remainder equals the dividend.
- R10: In signed mode, the most negative value divided by -1 gives the most negative value as the quotient and 0 as the remainder.
- R11: `quotient` and `remainder` change only when a calculation completes. They hold their values while `ready` is 1 and while a calculation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe, one write per high cycle |
| wr_sel | input | 2 | Write address: bit 0 operand, bit 1 signed mode |
| wr_data | input | WIDTH | Operand value written |
| ready | output | 1 | High when no calculation is running |
| quotient | output | WIDTH | Quotient of the last completed calculation |
| remainder | output | WIDTH | Remainder of the last completed calculation |

## Verification
The bench builds the block with its default parameters, WIDTH=32 and STEP_BITS=4. This gives an eight-cycle calculation, which is short enough for random write gaps to land both inside and after it. Abandoned calculations and restarts driven from either operand therefore occur often. The 32-bit width brings the real corner operands within reach: 0x80000000 with -1, all ones, zero divisors and mixed signs. A behavioural model using 64-bit integer arithmetic predicts `ready` and the results on every cycle.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;

    // Write address decode: bit 0 picks the operand, bit 1 picks the mode
    typedef enum logic [1:0] {
        SEL_DIVIDEND_U = 2'b00,
        SEL_DIVISOR_U  = 2'b01,
        SEL_DIVIDEND_S = 2'b10,
        SEL_DIVISOR_S  = 2'b11
    } op_sel_e;

    // Sign bookkeeping captured when a calculation starts
    typedef struct packed {
        logic is_signed;
        logic neg_dividend;
        logic neg_divisor;
    } sign_info_t;

    function automatic logic sel_is_divisor(input op_sel_e s);
        return (s == SEL_DIVISOR_U) || (s == SEL_DIVISOR_S);
    endfunction

    function automatic logic sel_is_signed(input op_sel_e s);
        return (s == SEL_DIVIDEND_S) || (s == SEL_DIVISOR_S);
    endfunction

endpackage

// File: rtl/regdiv_operands.sv
module regdiv_operands
    import regdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  op_sel_e          wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dividend_nxt,
    output logic [WIDTH-1:0] divisor_nxt
);

    logic [WIDTH-1:0] dividend_q;
    logic [WIDTH-1:0] divisor_q;
    logic             hit_divisor;

    assign hit_divisor = sel_is_divisor(wr_sel);

    // Write-through view so a starting calculation sees the value being written
    always_comb begin
        dividend_nxt = dividend_q;
        divisor_nxt  = divisor_q;
        if (wr_en && !hit_divisor) dividend_nxt = wr_data;
        if (wr_en &&  hit_divisor) divisor_nxt  = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dividend_q <= '0;
            divisor_q  <= '0;
        end else begin
            dividend_q <= dividend_nxt;
            divisor_q  <= divisor_nxt;
        end
    end

    // R2: both aliases of one operand land in one word; the other word is untouched
    a_r2_dividend_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel[0]) |=> (dividend_q == $past(wr_data)) && $stable(divisor_q));
    a_r2_divisor_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel[0]) |=> (divisor_q == $past(wr_data)) && $stable(dividend_q));

endmodule

// File: rtl/regdiv_step.sv
module regdiv_step #(
    parameter int WIDTH     = 32,
    parameter int STEP_BITS = 4
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] quo_out
);

    logic [WIDTH-1:0] rem_chain [0:STEP_BITS];
    logic [WIDTH-1:0] quo_chain [0:STEP_BITS];

    assign rem_chain[0] = rem_in;
    assign quo_chain[0] = quo_in;

    // One restoring shift-subtract stage per quotient bit retired this cycle
    for (genvar i = 0; i < STEP_BITS; i++) begin : g_stage
        logic [WIDTH:0] shifted;
        logic [WIDTH:0] diff;
        logic           fits;

        assign shifted = {rem_chain[i], quo_chain[i][WIDTH-1]};
        assign diff    = shifted - {1'b0, divisor};
        assign fits    = shifted >= {1'b0, divisor};

        assign rem_chain[i+1] = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
        assign quo_chain[i+1] = {quo_chain[i][WIDTH-2:0], fits};
    end

    assign rem_out = rem_chain[STEP_BITS];
    assign quo_out = quo_chain[STEP_BITS];

endmodule

// File: rtl/regdiv_engine.sv
module regdiv_engine
    import regdiv_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int STEP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             ready,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);

    localparam int STEPS = WIDTH / STEP_BITS;
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic             busy;
    logic [CW-1:0]    step_cnt;
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvs_q;
    sign_info_t       sinfo_q;
    sign_info_t       sinfo_d;
    logic [WIDTH-1:0] dvd_mag;
    logic [WIDTH-1:0] dvs_mag;
    logic [WIDTH-1:0] rem_step;
    logic [WIDTH-1:0] quo_step;
    logic [WIDTH-1:0] quo_fixed;
    logic [WIDTH-1:0] rem_fixed;

    // Magnitudes of the operands for the unsigned core
    always_comb begin
        sinfo_d.is_signed    = start_signed;
        sinfo_d.neg_dividend = start_signed & dividend[WIDTH-1];
        sinfo_d.neg_divisor  = start_signed & divisor[WIDTH-1];
        dvd_mag = sinfo_d.neg_dividend ? (~dividend + 1'b1) : dividend;
        dvs_mag = sinfo_d.neg_divisor  ? (~divisor  + 1'b1) : divisor;
    end

    regdiv_step #(
        .WIDTH     (WIDTH),
        .STEP_BITS (STEP_BITS)
    ) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .divisor (dvs_q),
        .rem_out (rem_step),
        .quo_out (quo_step)
    );

    // Sign restoration: quotient negated on mixed signs, remainder follows dividend
    always_comb begin
        quo_fixed = quo_step;
        rem_fixed = rem_step;
        if (sinfo_q.is_signed) begin
            if (sinfo_q.neg_dividend ^ sinfo_q.neg_divisor) quo_fixed = ~quo_step + 1'b1;
            if (sinfo_q.neg_dividend)                       rem_fixed = ~rem_step + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            step_cnt  <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            sinfo_q   <= '0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            step_cnt <= '0;
            rem_q    <= '0;
            quo_q    <= dvd_mag;
            dvs_q    <= dvs_mag;
            sinfo_q  <= sinfo_d;
        end else if (busy) begin
            rem_q    <= rem_step;
            quo_q    <= quo_step;
            step_cnt <= step_cnt + 1'b1;
            if (step_cnt == LAST) begin
                busy      <= 1'b0;
                quotient  <= quo_fixed;
                remainder <= rem_fixed;
            end
        end
    end

    assign ready = ~busy;

    // R3: a start always takes the engine out of the ready state
    a_r3_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);
    // R3: the step counter never runs past the last step
    a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_cnt <= LAST));
    // R6: the partial remainder stays below a nonzero divisor
    a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        busy && (dvs_q != '0) |-> (rem_q < dvs_q));
    // R11: results hold while idle and no new write arrives
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready && $stable(quotient) && $stable(remainder));
    // R11: results hold through a step that is not the last one
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && (step_cnt != LAST)) |=> $stable(quotient) && $stable(remainder));

endmodule

// File: rtl/regdiv_unit.sv
module regdiv_unit
    import regdiv_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int STEP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic             ready,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);

    op_sel_e          sel;
    logic [WIDTH-1:0] dividend_nxt;
    logic [WIDTH-1:0] divisor_nxt;

    assign sel = op_sel_e'(wr_sel);

    regdiv_operands #(
        .WIDTH (WIDTH)
    ) u_ops (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (sel),
        .wr_data      (wr_data),
        .dividend_nxt (dividend_nxt),
        .divisor_nxt  (divisor_nxt)
    );

    // Any operand write restarts the engine in the mode of the address used
    regdiv_engine #(
        .WIDTH     (WIDTH),
        .STEP_BITS (STEP_BITS)
    ) u_engine (
        .clk          (clk),
        .rst          (rst),
        .start        (wr_en),
        .start_signed (sel_is_signed(sel)),
        .dividend     (dividend_nxt),
        .divisor      (divisor_nxt),
        .ready        (ready),
        .quotient     (quotient),
        .remainder    (remainder)
    );

endmodule

// File: tb/sim_regdiv_unit.sv
`timescale 1ns/1ps
module sim_regdiv_unit;

    localparam int W     = 32;
    localparam int SB    = 4;
    localparam int STEPS = W / SB;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'b00;
    logic [W-1:0] wr_data = '0;
    logic         ready;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Behavioural model state
    logic [W-1:0] m_dvd, m_dvs, m_q, m_r;
    logic         m_sgn;
    int           m_cnt;
    logic         m_ready;

    regdiv_unit #(.WIDTH(W), .STEP_BITS(SB)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ready     (ready),
        .quotient  (quotient),
        .remainder (remainder)
    );

    always #2 clk = ~clk;

    task automatic check_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic sgn, output logic [W-1:0] q,
                                    output logic [W-1:0] r);
        longint sa, sb;
        if (!sgn) begin
            if (b == 0) begin q = '1; r = a; end
            else begin q = a / b; r = a % b; end
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            if (sb == 0) begin
                q = (sa < 0) ? W'(1) : '1;
                r = a;
            end else begin
                q = W'(sa / sb);
                r = W'(sa % sb);
            end
        end
    endfunction

    // Cycle model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_dvd = '0; m_dvs = '0; m_q = '0; m_r = '0;
            m_sgn = 1'b0; m_cnt = 0; m_ready = 1'b1;
        end else if (wr_en) begin
            if (wr_sel[0]) m_dvs = wr_data;
            else           m_dvd = wr_data;
            m_sgn   = wr_sel[1];
            m_cnt   = STEPS;
            m_ready = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                ref_div(m_dvd, m_dvs, m_sgn, m_q, m_r);
                m_ready = 1'b1;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check_val({cur_req, " ready"}, {31'd0, ready}, {31'd0, m_ready});
            check_val({cur_req, " R11 quotient"}, quotient, m_q);
            check_val({cur_req, " R11 remainder"}, remainder, m_r);
        end
    end

    task automatic do_write(input logic [1:0] sel, input logic [W-1:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_ready(output int low_cycles);
        low_cycles = 0;
        forever begin
            @(negedge clk);
            if (ready) break;
            low_cycles++;
        end
        #0.5;
    endtask

    task automatic div_case(input string req, input logic [1:0] dsel, input logic [W-1:0] a,
                            input logic [1:0] vsel, input logic [W-1:0] b,
                            input logic [W-1:0] eq, input logic [W-1:0] er);
        int lc;
        cur_req = req;
        do_write(dsel, a);
        do_write(vsel, b);
        wait_ready(lc);
        check_val({req, " quotient"}, quotient, eq);
        check_val({req, " remainder"}, remainder, er);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        int lc;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_val("R1 ready", {31'd0, ready}, 32'd1);
        check_val("R1 quotient", quotient, '0);
        check_val("R1 remainder", remainder, '0);
        // R1: dividend word is zero after reset
        cur_req = "R1";
        do_write(2'b01, 32'd7);
        wait_ready(lc);
        check_val("R1 zero dividend q", quotient, '0);
        check_val("R1 zero dividend r", remainder, '0);

        // R3: latency measured from the write edge
        cur_req = "R3";
        do_write(2'b00, 32'd100);
        wait_ready(lc);
        check_val("R3 ready low cycles", W'(lc), W'(STEPS));
        check_val("R3 result q", quotient, 32'd14);
        check_val("R3 result r", remainder, 32'd2);

        // R6: unsigned
        div_case("R6 small", 2'b00, 32'd1000, 2'b01, 32'd33, 32'd30, 32'd10);
        div_case("R6 allones", 2'b00, 32'hFFFF_FFFF, 2'b01, 32'h10, 32'h0FFF_FFFF, 32'hF);
        div_case("R6 big divisor", 2'b00, 32'h1234, 2'b01, 32'h8000_0000, 32'd0, 32'h1234);

        // R7: signed truncation toward zero
        div_case("R7 neg/pos", 2'b10, -32'sd7, 2'b11, 32'd2, -32'sd3, -32'sd1);
        div_case("R7 pos/neg", 2'b10, 32'd7, 2'b11, -32'sd2, -32'sd3, 32'd1);
        div_case("R7 neg/neg", 2'b10, -32'sd9, 2'b11, -32'sd4, 32'd2, -32'sd1);

        // R2 and R5: shared word, mode follows the latest write
        div_case("R2 alias shared", 2'b00, 32'hFFFF_FFF9, 2'b11, 32'd2, -32'sd3, -32'sd1);
        cur_req = "R5";
        do_write(2'b01, 32'd2);
        wait_ready(lc);
        check_val("R5 unsigned again q", quotient, 32'h7FFF_FFFC);
        check_val("R5 unsigned again r", remainder, 32'd1);
        do_write(2'b10, 32'hFFFF_FFF9);
        wait_ready(lc);
        check_val("R5 signed via dividend q", quotient, -32'sd3);

        // R8, R9: divide by zero
        div_case("R8 unsigned by zero", 2'b00, 32'd1234, 2'b01, 32'd0, 32'hFFFF_FFFF, 32'd1234);
        div_case("R9 signed pos by zero", 2'b10, 32'd5, 2'b11, 32'd0, 32'hFFFF_FFFF, 32'd5);
        div_case("R9 signed neg by zero", 2'b10, -32'sd5, 2'b11, 32'd0, 32'd1, -32'sd5);

        // R10: overflow case
        div_case("R10 min by -1", 2'b10, 32'h8000_0000, 2'b11, 32'hFFFF_FFFF, 32'h8000_0000, 32'd0);

        // R4: restart mid-calculation
        cur_req = "R4";
        do_write(2'b00, 32'd500);
        repeat (3) @(posedge clk);
        do_write(2'b01, 32'd7);
        wait_ready(lc);
        check_val("R4 ready low after restart", W'(lc), W'(STEPS));
        check_val("R4 restarted q", quotient, 32'd71);
        check_val("R4 restarted r", remainder, 32'd3);

        // R11: results hold while idle
        cur_req = "R11";
        repeat (5) @(negedge clk);
        check_val("R11 hold q", quotient, 32'd71);

        // Random traffic with gaps shorter and longer than a calculation
        cur_req = "R4 random";
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] d;
            case ($urandom % 6)
                0: d = 32'h8000_0000;
                1: d = 32'hFFFF_FFFF;
                2: d = 32'd0;
                3: d = W'($urandom % 17);
                default: d = W'($urandom);
            endcase
            do_write(2'($urandom % 4), d);
            repeat ($urandom % 12) @(posedge clk);
        end
        wait_ready(lc);
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule